// File: doc/BRIEF.md
# Preamble Chip Sequence Generator

This block emits the chip stream that opens a transmission. Three configuration bytes describe the stream. One byte is a repetition count. The other two together form a 16-chip pattern: the low byte supplies chips 0 to 7 and the high byte supplies chips 8 to 15. The block samples the configuration when it accepts a start pulse, so the inputs may change afterwards without affecting the burst in progress.

After an accepted start, each cycle in which `chip_en` is high shifts out one chip. The lowest pattern bit goes first. The pattern is sent once for each repetition configured. When the last chip of the last repetition leaves, `busy` drops and `done` pulses for one cycle. A repetition count of zero suppresses the preamble: `done` pulses right after the start and no chip is emitted. The unit that follows the preamble watches `done` to hand over to the next part of the frame.

Top module: `preamble_gen`

## Requirements
- R1: During and straight after reset, `busy`, `done` and `chip` are all 0.
- R2: A start pulse seen while idle, with a non-zero count, raises `busy` on the next rising edge.
- R3: The pattern is `{pat_hi, pat_lo}` (bit 0 = `pat_lo[0]`, bit 15 = `pat_hi[7]`). Within every repetition, the k-th chip emitted is pattern bit k, for k = 0 to 15.
- R4: `chip` takes its next value at the rising edge that ends a cycle in which `busy` and `chip_en` are both high. At every other edge `chip` keeps its value.
- R5: A burst with count N > 0 emits exactly 16·N chips, the whole pattern N times over.
- R6: The edge that emits the final chip also clears `busy` and raises `done`. `done` is high for that one cycle only, and never while `busy` is high.
- R7: A start with count 0 emits no chip. `busy` stays low and `done` is high during the cycle after the start edge.
- R8: A start pulse that arrives while `busy` is high is ignored: the running burst keeps its length and pattern.
- R9: The configuration inputs are sampled only when a start is accepted. Changing them during a burst has no effect on that burst.
- R10: Every count from 1 to 255 is honoured, including 255 (4080 chips).
- R11: `chip_en` while idle, or in the same cycle as an accepted start, emits nothing and leaves `chip` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a burst when idle |
| chip_en | input | 1 | Chip strobe; one chip per high cycle while busy |
| cfg_reps | input | 8 | Repetition count; 0 disables the preamble |
| cfg_pat_lo | input | 8 | Pattern chips 0..7 |
| cfg_pat_hi | input | 8 | Pattern chips 8..15 |
| chip | output | 1 | Current chip, held between strobes |
| busy | output | 1 | High while a burst is in progress |
| done | output | 1 | One-cycle pulse when a burst ends |

## Verification
Every output comes from a single register stage. `busy` rises, or `done` pulses for a zero count, one edge after the start edge. `chip` changes one edge after each strobe cycle. `done` and the fall of `busy` share the edge that emits the last chip. The bench drives its inputs on falling edges and updates a queue-based model on rising edges. It compares all three outputs at the next falling edge, so each expected value is due exactly one edge after the stimulus that causes it. Counts of emitted chips, and targeted checks after a zero-count start and while the block is idle, confirm the burst lengths and the cases where nothing happens.

// File: rtl/preamble_pkg.sv
package preamble_pkg;
   localparam int unsigned BYTE_BITS   = 8;
   localparam int unsigned PAT_BYTES   = 2;
   localparam int unsigned PAT_BITS    = BYTE_BITS * PAT_BYTES;
   localparam logic [PAT_BITS-1:0] DEF_PATTERN = 16'h3333;
   localparam logic [BYTE_BITS-1:0] DEF_REPS   = 8'd2;

   typedef enum logic {
      ORDER_LSB_FIRST = 1'b0,
      ORDER_MSB_FIRST = 1'b1
   } chip_order_e;
endpackage

// File: rtl/preamble_cfg_latch.sv
module preamble_cfg_latch
   import preamble_pkg::*;
#(
   parameter int unsigned BYTE_W  = BYTE_BITS,
   parameter int unsigned N_BYTES = PAT_BYTES,
   parameter logic [BYTE_W*N_BYTES-1:0] RST_PAT = DEF_PATTERN
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [BYTE_W*N_BYTES-1:0] pat_in,
   output logic [BYTE_W*N_BYTES-1:0] pat_q
);
   localparam int unsigned W = BYTE_W * N_BYTES;

   if (BYTE_W < 1 || N_BYTES < 1) begin : g_bad_geom
      $error("preamble_cfg_latch: byte width and byte count must be non-zero");
   end

   for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pat_q[b*BYTE_W +: BYTE_W] <= RST_PAT[b*BYTE_W +: BYTE_W];
         else if (load)
            pat_q[b*BYTE_W +: BYTE_W] <= pat_in[b*BYTE_W +: BYTE_W];
      end
   end

   // R9: stored pattern moves only when a start is accepted
   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(pat_q))
      else $error("p_cfg_frozen_r9");

   logic unused_w;
   assign unused_w = (W == 0);
endmodule

// File: rtl/preamble_serializer.sv
module preamble_serializer
   import preamble_pkg::*;
#(
   parameter int unsigned PAT_W = PAT_BITS,
   parameter chip_order_e ORDER = ORDER_LSB_FIRST
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [PAT_W-1:0] pat,
   output logic             chip,
   output logic             idx_last
);
   localparam int unsigned IDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAT_W - 1);

   if (PAT_W < 2) begin : g_bad_width
      $error("preamble_serializer: pattern must hold at least two chips");
   end

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] sel;

   if (ORDER == ORDER_LSB_FIRST) begin : g_lsb
      assign sel = idx_q;
   end else begin : g_msb
      assign sel = LAST_IDX - idx_q;
   end

   assign idx_last = (idx_q == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         chip  <= 1'b0;
      end else if (clear) begin
         idx_q <= '0;
      end else if (step) begin
         chip  <= pat[sel];
         idx_q <= idx_last ? '0 : idx_q + 1'b1;
      end
   end

   // R4: chip output holds unless a strobe is taken
   p_chip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(chip))
      else $error("p_chip_hold_r4");

   // R3: chip index restarts at zero on every accepted start
   p_idx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !idx_last || (PAT_W == 1))
      else $error("p_idx_clear_r3");
endmodule

// File: rtl/preamble_rep_ctrl.sv
module preamble_rep_ctrl
   import preamble_pkg::*;
#(
   parameter int unsigned CNT_W = BYTE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             chip_en,
   input  logic [CNT_W-1:0] reps_in,
   input  logic             idx_last,
   output logic             accept,
   output logic             step,
   output logic             busy,
   output logic             done
);
   if (CNT_W < 8) begin : g_bad_cnt
      $error("preamble_rep_ctrl: count must reach at least 255");
   end

   logic [CNT_W-1:0] reps_left;
   logic             wrap;
   logic             final_chip;

   assign accept     = start & ~busy;
   assign step       = busy & chip_en;
   assign wrap       = step & idx_last;
   assign final_chip = wrap & (reps_left == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         reps_left <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            if (reps_in == '0) begin
               done <= 1'b1;
            end else begin
               busy      <= 1'b1;
               reps_left <= reps_in;
            end
         end else if (final_chip) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            reps_left <= '0;
         end else if (wrap) begin
            reps_left <= reps_left - 1'b1;
         end
      end
   end

   // R2: a non-zero start turns busy on
   p_busy_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (reps_in != '0) |=> busy)
      else $error("p_busy_on_r2");

   // R7: zero count gives done without a burst
   p_zero_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (reps_in == '0) |=> done && !busy)
      else $error("p_zero_skip_r7");

   // R6: done and busy are never high together
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy)
      else $error("p_done_idle_r6");

   // R6: last chip ends the burst with done
   p_end_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      final_chip |=> done && !busy)
      else $error("p_end_burst_r6");

   // R8: a start during a burst leaves the repetition state alone
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start && !wrap |=> busy && $stable(reps_left))
      else $error("p_start_ignored_r8");
endmodule

// File: rtl/preamble_gen.sv
module preamble_gen
   import preamble_pkg::*;
#(
   parameter int unsigned BYTE_W  = BYTE_BITS,
   parameter int unsigned CNT_W   = BYTE_BITS,
   parameter chip_order_e ORDER   = ORDER_LSB_FIRST,
   parameter logic [2*BYTE_W-1:0] RST_PAT = DEF_PATTERN
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              chip_en,
   input  logic [CNT_W-1:0]  cfg_reps,
   input  logic [BYTE_W-1:0] cfg_pat_lo,
   input  logic [BYTE_W-1:0] cfg_pat_hi,
   output logic              chip,
   output logic              busy,
   output logic              done
);
   localparam int unsigned PAT_W = 2 * BYTE_W;

   logic             accept;
   logic             step;
   logic             idx_last;
   logic [PAT_W-1:0] pat_q;

   preamble_rep_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .chip_en  (chip_en),
      .reps_in  (cfg_reps),
      .idx_last (idx_last),
      .accept   (accept),
      .step     (step),
      .busy     (busy),
      .done     (done)
   );

   preamble_cfg_latch #(.BYTE_W(BYTE_W), .N_BYTES(2), .RST_PAT(RST_PAT)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .pat_in ({cfg_pat_hi, cfg_pat_lo}),
      .pat_q  (pat_q)
   );

   preamble_serializer #(.PAT_W(PAT_W), .ORDER(ORDER)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .step     (step),
      .pat      (pat_q),
      .chip     (chip),
      .idx_last (idx_last)
   );
endmodule

// File: tb/preamble_gen_test.sv
module preamble_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       chip_en = 1'b0;
   logic [7:0] cfg_reps = 8'd0;
   logic [7:0] cfg_pat_lo = 8'd0;
   logic [7:0] cfg_pat_hi = 8'd0;
   logic       chip, busy, done;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cycles = 0;
   int    steps_seen = 0;
   string req = "R1";
   logic [15:0] lfsr = 16'hACE1;

   // behavioural model
   bit m_busy = 0, m_done = 0, m_chip = 0;
   bit chip_q[$];

   always #2 clk = ~clk;

   preamble_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .chip_en(chip_en),
      .cfg_reps(cfg_reps), .cfg_pat_lo(cfg_pat_lo), .cfg_pat_hi(cfg_pat_hi),
      .chip(chip), .busy(busy), .done(done)
   );

   always @(posedge clk) begin
      bit nd;
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_chip = 0; chip_q.delete();
      end else begin
         nd = 0;
         if (busy && chip_en) steps_seen++;
         if (m_busy && chip_en) begin
            m_chip = chip_q.pop_front();
            if (chip_q.size() == 0) begin m_busy = 0; nd = 1; end
         end else if (!m_busy && start) begin
            if (cfg_reps == 0) nd = 1;
            else begin
               for (int r = 0; r < cfg_reps; r++)
                  for (int k = 0; k < 16; k++)
                     chip_q.push_back(k < 8 ? cfg_pat_lo[k] : cfg_pat_hi[k-8]);
               m_busy = 1;
            end
         end
         m_done = nd;
      end
   end

   task automatic check(string r, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         cycles++;
         check(req, "busy", busy, m_busy);
         check(req, "done", done, m_done);
         check(req, "chip", chip, m_chip);
      end
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   task automatic kick(int reps, int lo, int hi, bit en);
      @(negedge clk);
      cfg_reps = 8'(reps); cfg_pat_lo = 8'(lo); cfg_pat_hi = 8'(hi);
      start = 1'b1; chip_en = en;
      @(negedge clk);
      start = 1'b0;
   endtask

   // mode 0: strobe off, 1: always, 2: pseudo-random
   task automatic run(int n, int mode);
      for (int i = 0; i < n; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         chip_en = (mode == 1) ? 1'b1 : (mode == 2) ? lfsr[0] : 1'b0;
         @(negedge clk);
      end
      chip_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      check("R1", "reset busy", busy, 0);
      check("R1", "reset done", done, 0);
      check("R1", "reset chip", chip, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "post-reset busy", busy, 0);

      // R3: chip order, single repetition, continuous strobe
      req = "R3";
      kick(1, 8'hA5, 8'hC3, 1'b0);
      run(20, 1);

      // R4 and R5: gapped strobe, three repetitions
      req = "R4";
      steps_seen = 0;
      kick(3, 8'h96, 8'h1E, 1'b0);
      run(140, 2);
      run(10, 1);
      check("R5", "chips in 3-rep burst", steps_seen, 48);

      // R8 and R9: start and config changes during a burst
      req = "R8";
      steps_seen = 0;
      kick(2, 8'h0F, 8'h0F, 1'b0);
      chip_en = 1'b1;
      @(negedge clk);
      req = "R9";
      cfg_reps = 8'd7; cfg_pat_lo = 8'hF0; cfg_pat_hi = 8'h55; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      run(40, 1);
      check("R8", "chips with ignored start", steps_seen, 32);

      // R7: zero count disables the preamble
      req = "R7";
      steps_seen = 0;
      @(negedge clk);
      cfg_reps = 8'd0; cfg_pat_lo = 8'hFF; cfg_pat_hi = 8'hFF; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R7", "done after zero start", done, 1);
      check("R7", "busy after zero start", busy, 0);
      run(5, 1);
      check("R7", "chips for zero count", steps_seen, 0);

      // R11: strobe while idle leaves chip unchanged
      req = "R11";
      begin
         int held;
         held = chip;
         run(10, 1);
         check("R11", "idle chip held", chip, held);
      end

      // R2 and R6: strobe in the start cycle, then end of burst
      req = "R2";
      kick(1, 8'h01, 8'h80, 1'b1);
      check("R2", "busy after start", busy, 1);
      req = "R6";
      run(20, 1);

      // R10: maximum count
      req = "R10";
      steps_seen = 0;
      kick(255, 8'h33, 8'h33, 1'b0);
      run(4100, 1);
      check("R10", "chips in 255-rep burst", steps_seen, 4080);
      check("R10", "idle after max burst", busy, 0);

      finish_run();
   end
endmodule